// File: doc/BRIEF.md
# Ordered-Write Bootloader Unlock Detector

This block sits behind a simple 32-bit memory-mapped register bus and watches writes to a trigger register. Only the low byte of each trigger write counts. The block compares that byte against a fixed eight-byte key. When the whole key arrives in the right order, the block enters bootloader mode.

While in bootloader mode it holds an output that keeps the application device disabled. It also exposes an identification word at its ID register. A control write can leave bootloader mode, and another control write requests a one-cycle software reset pulse.

A version constant is always readable from the control register. The ID word reads as zero until the key has been accepted. All state uses a synchronous active-low reset.

Top module: `boot_unlock_ctrl`

## Requirements
- R1: After reset the block is locked: `app_disable_o` is 0, `soft_rst_o` is 0, and the ID register (offset 0xC) reads 0.
- R2: Writing the bytes 0xDE, 0xAD, 0xBE, 0xEF, 0xCA, 0xFE, 0xBA, 0xBE in that order to offset 0x4 sets bootloader mode in the cycle after the eighth write. After only seven of them the block is still locked.
- R3: Only bits 7:0 of a trigger write are compared; bits 31:8 have no effect on matching.
- R4: A trigger byte that differs from the next expected key byte sends the match position back to the start. If that byte is 0xDE, it counts as the first key byte instead.
- R5: Writes to offsets other than 0x4 leave the match position unchanged, so they may be interleaved with the key bytes.
- R6: While in bootloader mode the ID register reads 0x53564543; while locked it reads 0.
- R7: The control register (offset 0x0) reads the version value 2 in bits 21:14, and 0 in every other bit, including the write-only bits 5 and 6. Offsets 0x4, 0x8 and all unmapped offsets read 0.
- R8: Writing offset 0x0 with bit 6 set leaves bootloader mode in the next cycle. A full key is then needed to unlock again.
- R9: Writing offset 0x0 with bit 5 set drives `soft_rst_o` high for exactly the one cycle after that write. This happens in either mode and does not change the mode.
- R10: Trigger writes made while in bootloader mode have no effect: the mode stays set, and no progress toward a later unlock is kept.
- R11: `app_disable_o` is high exactly while bootloader mode is set, and a hardware reset clears that mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| app_disable_o | output | 1 | Holds the application device disabled while in bootloader mode |
| soft_rst_o | output | 1 | One-cycle software reset request |

## Verification
The bench breaks off the key after every prefix length, using two kinds of wrong byte: one that is neither the expected byte nor 0xDE, and 0xDE itself.
- A matcher that does not restart on a wrong byte would unlock on a partial key.
- A matcher that ignores the 0xDE restart would miss a key that begins right after a stray 0xDE.

Further checks cover the following faults:
- Key bytes with noisy upper bits and interleaved writes to other offsets catch a design that compares the full word, or that resets its match position on unrelated writes.
- Feeding key bytes while unlocked, then leaving the mode, catches a matcher that keeps counting in bootloader mode and would later unlock on a single byte.
- Readback checks catch an ID word that leaks while locked, and write-only control bits that read back as set.
- Checks on the pulse width catch a soft reset that is held high or that changes the mode.

// File: rtl/boot_unlock_pkg.sv
// Shared constants for the bootloader unlock detector: register offsets,
// control bit positions, identification values and the unlock key.
package boot_unlock_pkg;

    localparam int KEY_LEN   = 8;
    localparam int OFS_CSR   = 0;
    localparam int OFS_TRIG  = 4;
    localparam int OFS_ID    = 12;
    localparam int BIT_SRST  = 5;
    localparam int BIT_EXIT  = 6;
    localparam int VER_LSB   = 14;
    localparam int VER_W     = 8;
    localparam logic [31:0] ID_WORD = 32'h5356_4543;

    // Key byte expected at a given match position.
    function automatic logic [7:0] key_byte(input int idx);
        case (idx)
            0:       key_byte = 8'hDE;
            1:       key_byte = 8'hAD;
            2:       key_byte = 8'hBE;
            3:       key_byte = 8'hEF;
            4:       key_byte = 8'hCA;
            5:       key_byte = 8'hFE;
            6:       key_byte = 8'hBA;
            default: key_byte = 8'hBE;
        endcase
    endfunction

endpackage

// File: rtl/unlock_key_matcher.sv
// Tracks how far the ordered key has been received.
// Assumes: trig_wr is a single-cycle strobe per trigger write; armed is low
// while bootloader mode is set, and writes are then ignored.
module unlock_key_matcher #(
    parameter int KEY_LEN = 8,
    localparam int POS_W  = $clog2(KEY_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       trig_wr,
    input  logic [7:0] trig_byte,
    output logic       unlock_o
);
    import boot_unlock_pkg::*;

    logic [POS_W-1:0] pos_q;
    logic [7:0]       want;
    logic             hit;
    logic             last;

    // Expected byte at the current position and the compare result.
    always_comb begin
        want     = key_byte(int'(pos_q));
        hit      = (trig_byte == want);
        last     = (pos_q == POS_W'(KEY_LEN - 1));
        unlock_o = armed && trig_wr && hit && last;
    end

    // Advance on a match, restart on a miss (a leading key byte counts as position 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (armed && trig_wr) begin
            if (hit && !last)
                pos_q <= pos_q + POS_W'(1);
            else if (hit)
                pos_q <= '0;
            else if (trig_byte == key_byte(0))
                pos_q <= POS_W'(1);
            else
                pos_q <= '0;
        end
    end

endmodule

// File: rtl/boot_mode_ctl.sv
// Holds the bootloader mode flag and produces the software reset pulse.
// Assumes: unlock and exit requests never coincide (they come from different offsets).
module boot_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock,
    input  logic exit_req,
    input  logic srst_req,
    output logic mode_o,
    output logic soft_rst_o
);

    // Mode flag: set on unlock, cleared by exit or hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_o <= 1'b0;
        else if (exit_req)
            mode_o <= 1'b0;
        else if (unlock)
            mode_o <= 1'b1;
    end

    // One-cycle software reset request following the control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            soft_rst_o <= 1'b0;
        else
            soft_rst_o <= srst_req;
    end

endmodule

// File: rtl/boot_readback_mux.sv
// Combinational read data: version in the control register, ID gated by mode.
// Assumes: a read is a pure function of the offset and the current mode.
module boot_readback_mux #(
    parameter int          ADDR_W  = 5,
    parameter logic [7:0]  VERSION = 8'd2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode,
    output logic [31:0]       rdata
);
    import boot_unlock_pkg::*;

    // Select the word for the requested offset; unmapped bits are zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CSR))
            rdata[VER_LSB +: VER_W] = VERSION;
        else if (addr == ADDR_W'(OFS_ID) && mode)
            rdata = ID_WORD;
    end

endmodule

// File: rtl/boot_unlock_ctrl.sv
// Top of the bootloader unlock detector: decodes bus writes, runs the key
// matcher, holds the mode flag and drives read data.
// Assumes: bus_we is high for one cycle per write; reads are combinational.
module boot_unlock_ctrl #(
    parameter int         ADDR_W  = 5,
    parameter logic [7:0] VERSION = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              app_disable_o,
    output logic              soft_rst_o
);
    import boot_unlock_pkg::*;

    logic trig_wr;
    logic csr_wr;
    logic exit_req;
    logic srst_req;
    logic unlock;
    logic mode;

    // Write decode per offset and per control bit.
    always_comb begin
        trig_wr  = bus_we && (bus_addr == ADDR_W'(OFS_TRIG));
        csr_wr   = bus_we && (bus_addr == ADDR_W'(OFS_CSR));
        exit_req = csr_wr && bus_wdata[BIT_EXIT];
        srst_req = csr_wr && bus_wdata[BIT_SRST];
    end

    unlock_key_matcher #(.KEY_LEN(KEY_LEN)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (!mode),
        .trig_wr   (trig_wr),
        .trig_byte (bus_wdata[7:0]),
        .unlock_o  (unlock)
    );

    boot_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock     (unlock),
        .exit_req   (exit_req),
        .srst_req   (srst_req),
        .mode_o     (mode),
        .soft_rst_o (soft_rst_o)
    );

    boot_readback_mux #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_rd (
        .addr  (bus_addr),
        .mode  (mode),
        .rdata (bus_rdata)
    );

    assign app_disable_o = mode;

endmodule

// File: rtl/boot_unlock_chk.sv
// Port-level properties of the unlock detector, bound to the top module.
module boot_unlock_chk #(
    parameter int         ADDR_W  = 5,
    parameter logic [7:0] VERSION = 8'd2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              app_disable_o,
    input logic              soft_rst_o
);

    // R2: entering the mode always follows a trigger write of the last key byte.
    p_unlock_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_disable_o) |-> $past(bus_we && bus_addr == ADDR_W'(4) && bus_wdata[7:0] == 8'hBE));

    // R8: an exit write clears the mode in the next cycle.
    p_exit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(0) && bus_wdata[6]) |=> !app_disable_o);

    // R10: without an exit write the mode holds.
    p_mode_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (app_disable_o && !(bus_we && bus_addr == ADDR_W'(0) && bus_wdata[6])) |=> app_disable_o);

    // R9: the reset pulse only follows a control write with bit 5 set.
    p_srst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(bus_we && bus_addr == ADDR_W'(0) && bus_wdata[5]));

    // R6: the ID word is hidden while locked.
    p_id_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(12) && !app_disable_o) |-> bus_rdata == 32'h0);

    // R7: control register shows the version and zero write-only bits.
    p_csr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata[21:14] == VERSION && bus_rdata[6:5] == 2'b00));

endmodule

bind boot_unlock_ctrl boot_unlock_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .app_disable_o (app_disable_o),
    .soft_rst_o    (soft_rst_o)
);

// File: tb/boot_unlock_ctrl_tb.sv
`timescale 1ns/1ps
module boot_unlock_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        app_disable_o;
    logic        soft_rst_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [31:0] ID_EXP  = 32'h5356_4543;
    localparam logic [31:0] CSR_EXP = 32'd2 << 14;
    logic [7:0] key [8] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCA, 8'hFE, 8'hBA, 8'hBE};

    always #2.5 clk = ~clk;

    boot_unlock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .app_disable_o(app_disable_o), .soft_rst_o(soft_rst_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Write key bytes lo..hi to the trigger offset with noisy upper bits.
    task automatic send_key(input int lo, input int hi, input logic [23:0] noise);
        for (int i = lo; i <= hi; i++) wr(5'h4, {noise ^ 24'(i * 24'h1357), key[i]});
    endtask

    task automatic leave_mode();
        wr(5'h0, 32'h40);
        check("R8 mode cleared after exit", {31'b0, app_disable_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 app_disable after reset", {31'b0, app_disable_o}, 32'd0);
        check("R1 soft_rst after reset", {31'b0, soft_rst_o}, 32'd0);
        rd("R1 ID locked after reset", 5'hC, 32'd0);
        rd("R7 CSR version", 5'h0, CSR_EXP);
        rd("R7 trigger offset reads 0", 5'h4, 32'd0);
        rd("R7 offset 0x8 reads 0", 5'h8, 32'd0);

        // R4 sweep: break the key after each prefix length with two kinds of wrong byte.
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 2; v++) begin
                send_key(0, k - 1, 24'(k * 97 + v));
                wr(5'h4, {24'hF0F0F0, (v == 1) ? 8'hDE : 8'h11});
                if (v == 1) begin
                    send_key(1, 6, 24'hABCDEF);
                    check("R4 locked before last byte after DE restart", {31'b0, app_disable_o}, 32'd0);
                    send_key(7, 7, 24'h123456);
                    check("R4 DE restart unlocks", {31'b0, app_disable_o}, 32'd1);
                end else begin
                    send_key(1, 7, 24'h654321);
                    check("R4 miss restarts from zero", {31'b0, app_disable_o}, 32'd0);
                    send_key(0, 6, 24'hFFFFFF);
                    check("R2 locked after seven bytes", {31'b0, app_disable_o}, 32'd0);
                    send_key(7, 7, 24'h00FF00);
                    check("R2 R3 unlocked after full key", {31'b0, app_disable_o}, 32'd1);
                end
                rd("R6 ID when unlocked", 5'hC, ID_EXP);
                leave_mode();
                rd("R6 ID locked again", 5'hC, 32'd0);
            end
        end

        // R5: unrelated writes interleaved between key bytes.
        for (int i = 0; i < 8; i++) begin
            wr(5'h8, 32'hFFFF_FFFF);
            wr(5'h0, 32'h9F);
            wr(5'hC, 32'h1234_5678);
            send_key(i, i, 24'h0);
        end
        check("R5 interleaved writes still unlock", {31'b0, app_disable_o}, 32'd1);
        rd("R7 CSR in mode", 5'h0, CSR_EXP);
        wr(5'h0, 32'h20);
        check("R9 pulse high after write in mode", {31'b0, soft_rst_o}, 32'd1);
        check("R9 mode unchanged by soft reset", {31'b0, app_disable_o}, 32'd1);
        rd("R7 write-only bits read 0", 5'h0, CSR_EXP);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {31'b0, soft_rst_o}, 32'd0);

        // R10: key bytes while unlocked are ignored.
        send_key(0, 6, 24'h0);
        check("R10 mode stays with trigger writes", {31'b0, app_disable_o}, 32'd1);
        leave_mode();
        send_key(7, 7, 24'h0);
        check("R10 no progress kept from unlocked writes", {31'b0, app_disable_o}, 32'd0);

        // R8 / R9 while locked.
        wr(5'h0, 32'h40);
        check("R8 exit when locked keeps locked", {31'b0, app_disable_o}, 32'd0);
        wr(5'h0, 32'h20);
        check("R9 pulse while locked", {31'b0, soft_rst_o}, 32'd1);
        @(negedge clk);
        check("R9 pulse ends while locked", {31'b0, soft_rst_o}, 32'd0);

        // R11: hardware reset clears the mode.
        send_key(0, 7, 24'h777777);
        check("R11 app_disable follows mode", {31'b0, app_disable_o}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 hardware reset clears mode", {31'b0, app_disable_o}, 32'd0);
        rd("R1 ID zero after reset", 5'hC, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule